// File: doc/BRIEF.md
# Gated Timer Counter Channel

A single counting channel that lives entirely in the master clock domain. The count source is picked from five internal time bases, derived from a free-running prescaler, or from three external clock pins. The chosen source can be inverted, so that counting happens on its falling edges. A second selector can gate counting with one of the external pins, so that edges are counted only while that pin is high. External pins are brought into the master domain through two-flop synchronizers. Edges of the chosen source are found by comparing its level with a registered copy from the previous cycle.

The count is always visible on an output port. A software or hardware trigger does not clear the count at once. It is held pending and takes effect on the next valid counting edge, which loads zero in place of the increment. A wrap from all ones to zero sets a sticky overflow flag, and a status-read strobe clears it. Separate enable and disable commands start and stop counting. While stopped, the count holds and a pending trigger is kept.

The block suits event counting, interval timing and chained time bases. External pins must stay at each level for longer than one master clock period, and must toggle at no more than the master clock frequency divided by 2.5.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and counting is disabled. While enabled, the count rises by exactly one on each valid edge, and `count_o` shows it every cycle.
- R2: Select codes 0 to 4 choose square waves of master/2, /8, /32, /128 and /1024. These are bits 0, 2, 4, 6 and 9 of a 10-bit prescaler that starts at 0 on reset and adds one every cycle. Codes 5, 6 and 7 choose external pins 0, 1 and 2.
- R3: When a counting edge moves the count from all ones to zero, the overflow flag goes to 1 and stays at 1 without further wraps.
- R4: A status-read strobe clears the overflow flag one cycle later. If a wrap happens in the same cycle as the strobe, the flag stays set.
- R5: A trigger (either input, one-cycle pulse) is held pending. The first valid edge after the trigger cycle loads 0 instead of incrementing and consumes the pending trigger. An edge in the trigger cycle itself does not consume it.
- R6: With the invert control at 1, the count advances on falling edges of the selected source, and rising edges have no effect.
- R7: Gate code 0 means no gating. Gate codes 1, 2 and 3 choose external pin 0, 1 and 2, and edges count only while the synchronized gate pin is high.
- R8: An external pin is sampled by two flops and then edge-detected. A rising level first seen at a master clock edge increments the count at the third master clock edge, counting that first one.
- R9: An enable pulse sets `run_o` and a disable pulse clears it, with disable winning if both arrive together. While disabled, the count holds and a pending trigger stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| xclk_i | input | 3 | External clock / gate pins, asynchronous |
| clk_sel_i | input | 3 | Count source select (0-4 internal, 5-7 external) |
| clk_inv_i | input | 1 | Count on falling edges of the source |
| gate_sel_i | input | 2 | Gate select (0 none, 1-3 external pin 0-2) |
| en_cmd_i | input | 1 | Enable-counting pulse |
| dis_cmd_i | input | 1 | Disable-counting pulse |
| sw_trig_i | input | 1 | Software trigger pulse |
| hw_trig_i | input | 1 | Hardware trigger pulse |
| stat_rd_i | input | 1 | Status read strobe, clears overflow |
| count_o | output | CNT_W (16) | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| run_o | output | 1 | Counting enabled |

## Verification
Two situations are hard to reach from the ports. The first is a status read that lands in the exact cycle of a wrap. At 16 bits a wrap takes 65536 edges, so the bench also drives a second instance built with a 4-bit count from the same inputs. It then holds the read strobe high across several wraps of that instance, so the collision is certain to occur. The second is a trigger that waits through a disabled period. The bench produces it by pulsing single edges by hand on an external pin around disable, trigger and enable commands, so it knows exactly which edge must load zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_INT = 5;
  localparam int unsigned NUM_EXT = 3;
  localparam int unsigned PRE_W   = 10;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned GATE_W  = 2;

  // prescaler bit giving internal time base i: /2,/8,/32,/128,/1024
  function automatic int unsigned tap_bit(int unsigned i);
    return (i < 4) ? 2 * i : PRE_W - 1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned W = PRE_W,
  parameter int unsigned N = NUM_INT
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] lvl_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_tap
    assign lvl_o[g] = cnt_q[tap_bit(g)];
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_lvl,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               clk_inv,
  input  logic [GATE_W-1:0]  gate_sel,
  input  logic               run,
  input  logic               trig,
  input  logic               stat_rd,
  output logic [CNT_W-1:0]   count,
  output logic               ovf
);
  logic             sel_lvl, eff_lvl, lvl_prev_q, gate_ok, tick, step, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d, ovf_q, ovf_d;

  // source and gate multiplexers
  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < int'(NUM_INT); i++)
      if (clk_sel == SEL_W'(i)) sel_lvl = int_lvl[i];
    for (int j = 0; j < int'(NUM_EXT); j++)
      if (clk_sel == SEL_W'(int'(NUM_INT) + j)) sel_lvl = ext_lvl[j];
    gate_ok = (gate_sel == '0);
    for (int j = 0; j < int'(NUM_EXT); j++)
      if (gate_sel == GATE_W'(j + 1)) gate_ok = ext_lvl[j];
  end

  assign eff_lvl = sel_lvl ^ clk_inv;
  assign tick    = eff_lvl & ~lvl_prev_q;
  assign step    = tick & gate_ok & run;

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q | trig;
    wrap   = 1'b0;
    if (step) begin
      if (pend_q) begin
        cnt_d  = '0;
        pend_d = trig;
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = (cnt_q == '1);
      end
    end
    ovf_d = wrap | (ovf_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      lvl_prev_q <= eff_lvl;
      if (step) cnt_q <= cnt_d;
      pend_q     <= pend_d;
      ovf_q      <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       xclk_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             clk_inv_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             en_cmd_i,
  input  logic             dis_cmd_i,
  input  logic             sw_trig_i,
  input  logic             hw_trig_i,
  input  logic             stat_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             run_o
);
  logic [NUM_INT-1:0] int_lvl;
  logic [NUM_EXT-1:0] ext_lvl;
  logic               run_q, run_d;

  tmr_prescale #(.W(PRE_W), .N(NUM_INT)) u_pre (
    .clk(clk), .rst_n(rst_n), .lvl_o(int_lvl)
  );

  tmr_sync #(.W(NUM_EXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(xclk_i), .sync_o(ext_lvl)
  );

  always_comb begin
    run_d = run_q;
    if (en_cmd_i)  run_d = 1'b1;
    if (dis_cmd_i) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .int_lvl(int_lvl), .ext_lvl(ext_lvl),
    .clk_sel(clk_sel_i), .clk_inv(clk_inv_i), .gate_sel(gate_sel_i),
    .run(run_q), .trig(sw_trig_i | hw_trig_i), .stat_rd(stat_rd_i),
    .count(count_o), .ovf(ovf_o)
  );

  assign run_o = run_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_cmd_i,
  input logic             dis_cmd_i,
  input logic             stat_rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             run_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R1: count only moves by +1 or to zero
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));

  // R9: count frozen when counting was disabled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_o) |-> $stable(count_o));

  // R9: disable wins
  p_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_cmd_i) |-> !run_o);

  p_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_cmd_i && !dis_cmd_i) |-> run_o);

  // R3: flag rises only on a wrap
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(count_o) == MAXV && count_o == '0));

  // R4: read clears unless a wrap coincides
  p_rd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd_i) && !($past(count_o) == MAXV && count_o == '0)) |-> !ovf_o);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_cmd_i(en_cmd_i), .dis_cmd_i(dis_cmd_i),
  .stat_rd_i(stat_rd_i), .count_o(count_o), .ovf_o(ovf_o), .run_o(run_o)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module tmr_ref #(parameter int W = 16) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   xclk,
  input  logic [2:0]   sel,
  input  logic         inv,
  input  logic [1:0]   gsel,
  input  logic         en,
  input  logic         dis,
  input  logic         trig,
  input  logic         rd,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         run
);
  int pre;
  bit a0, a1, a2, b0, b1, b2, prev, pend;
  bit lv, g, ev, wrap;
  int taps[5] = '{0, 2, 4, 6, 9};

  function automatic bit pick(int k, bit x0, bit x1, bit x2);
    return (k == 0) ? x0 : (k == 1) ? x1 : x2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre = 0; a0 = 0; a1 = 0; a2 = 0; b0 = 0; b1 = 0; b2 = 0;
      prev = 0; pend = 0; cnt = '0; ovf = 0; run = 0;
    end else begin
      if (sel < 5) lv = ((pre >> taps[sel]) & 1) == 1;
      else         lv = pick(int'(sel) - 5, b0, b1, b2);
      lv   = lv ^ inv;
      g    = (gsel == 0) ? 1'b1 : pick(int'(gsel) - 1, b0, b1, b2);
      ev   = lv && !prev && g && run;
      wrap = 0;
      if (ev) begin
        if (pend) begin
          cnt  = '0;
          pend = trig;
        end else begin
          wrap = (cnt == {W{1'b1}});
          cnt  = cnt + 1'b1;
          pend = trig;
        end
      end else begin
        pend = pend | trig;
      end
      ovf  = wrap | (ovf & !rd);
      run  = dis ? 1'b0 : (en ? 1'b1 : run);
      prev = lv;
      b0 = a0; b1 = a1; b2 = a2;
      a0 = xclk[0]; a1 = xclk[1]; a2 = xclk[2];
      pre = (pre + 1) % 1024;
    end
  end
endmodule

module test_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  xclk, sel;
  logic        inv, en, dis, swt, hwt, rd;
  logic [1:0]  gsel;
  logic [15:0] count_o, r_cnt;
  logic        ovf_o, run_o, r_ovf, r_run;
  logic [3:0]  n_cnt, rn_cnt;
  logic        n_ovf, n_run, rn_ovf, rn_run;

  int    nchk = 0, nfail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr_chan i_tmr_chan (
    .clk(clk), .rst_n(rst_n), .xclk_i(xclk), .clk_sel_i(sel), .clk_inv_i(inv),
    .gate_sel_i(gsel), .en_cmd_i(en), .dis_cmd_i(dis), .sw_trig_i(swt),
    .hw_trig_i(hwt), .stat_rd_i(rd), .count_o(count_o), .ovf_o(ovf_o), .run_o(run_o)
  );

  tmr_chan #(.CNT_W(4)) i_tmr_chan_n (
    .clk(clk), .rst_n(rst_n), .xclk_i(xclk), .clk_sel_i(sel), .clk_inv_i(inv),
    .gate_sel_i(gsel), .en_cmd_i(en), .dis_cmd_i(dis), .sw_trig_i(swt),
    .hw_trig_i(hwt), .stat_rd_i(rd), .count_o(n_cnt), .ovf_o(n_ovf), .run_o(n_run)
  );

  tmr_ref #(.W(16)) i_ref (
    .clk(clk), .rst_n(rst_n), .xclk(xclk), .sel(sel), .inv(inv), .gsel(gsel),
    .en(en), .dis(dis), .trig(swt | hwt), .rd(rd), .cnt(r_cnt), .ovf(r_ovf), .run(r_run)
  );

  tmr_ref #(.W(4)) i_ref_n (
    .clk(clk), .rst_n(rst_n), .xclk(xclk), .sel(sel), .inv(inv), .gsel(gsel),
    .en(en), .dis(dis), .trig(swt | hwt), .rd(rd), .cnt(rn_cnt), .ovf(rn_ovf), .run(rn_run)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  // per-cycle comparison against the reference model, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(count_o == r_cnt, cur_req, count_o, r_cnt);
      chk(ovf_o == r_ovf, cur_req, ovf_o, r_ovf);
      chk(run_o == r_run, cur_req, run_o, r_run);
      chk(n_cnt == rn_cnt, cur_req, n_cnt, rn_cnt);
      chk(n_ovf == rn_ovf, cur_req, n_ovf, rn_ovf);
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin : main
    logic [15:0] c0;
    bit saw;
    xclk = '0; sel = '0; inv = 0; gsel = '0; en = 0; dis = 0;
    swt = 0; hwt = 0; rd = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(count_o == 0, "R1 reset count", count_o, 0);
    chk(ovf_o == 0, "R1 reset ovf", ovf_o, 0);
    chk(run_o == 0, "R1 reset run", run_o, 0);
    rst_n = 1;

    // R9: disabled, count holds
    cur_req = "R9";
    step(20);
    chk(count_o == 0, "R9 disabled hold", count_o, 0);
    en = 1; step(); en = 0;
    chk(run_o == 1, "R9 enable", run_o, 1);

    // R2: every internal time base
    cur_req = "R2";
    for (int s = 0; s < 5; s++) begin
      sel = 3'(s);
      c0 = count_o;
      step(2100);
      chk(count_o != c0, "R2 internal source advances", count_o, c0);
    end

    // R8: external pin latency
    cur_req = "R8";
    sel = 3'd5; xclk[0] = 0;
    step(6);
    c0 = count_o;
    xclk[0] = 1;
    step(2);
    chk(count_o == c0, "R8 not before third edge", count_o, c0);
    step();
    chk(count_o == c0 + 1, "R8 third edge R1 plus one", count_o, c0 + 1);
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) xclk[0] = ~xclk[0];
      step();
    end

    // R6: inverted counting
    cur_req = "R6";
    inv = 1; xclk[0] = 0;
    step(6);
    c0 = count_o;
    xclk[0] = 1;
    step(4);
    chk(count_o == c0, "R6 rising ignored", count_o, c0);
    xclk[0] = 0;
    step(2);
    chk(count_o == c0, "R6 fall latency", count_o, c0);
    step();
    chk(count_o == c0 + 1, "R6 falling counts", count_o, c0 + 1);
    inv = 0;
    step(4);

    // R7: burst gating on pin 0 with master/2
    cur_req = "R7";
    sel = 3'd0; gsel = 2'd1; xclk[0] = 0;
    step(5);
    c0 = count_o;
    step(20);
    chk(count_o == c0, "R7 gate low blocks", count_o, c0);
    xclk[0] = 1;
    step(20);
    chk(count_o > c0, "R7 gate high counts", count_o, c0);
    gsel = 2'd3; sel = 3'd6;
    for (int i = 0; i < 80; i++) begin
      if (i % 4 == 0) xclk[1] = ~xclk[1];
      if (i % 17 == 0) xclk[2] = ~xclk[2];
      step();
    end
    gsel = 2'd0; xclk = '0;
    step(6);

    // R5: trigger waits for the next valid edge
    cur_req = "R5";
    sel = 3'd5;
    c0 = count_o;
    hwt = 1; step(); hwt = 0;
    step(5);
    chk(count_o == c0, "R5 no immediate clear", count_o, c0);
    xclk[0] = 1; step(3);
    chk(count_o == 0, "R5 cleared on edge", count_o, 0);
    xclk[0] = 0; step(4);
    for (int i = 0; i < 2; i++) begin
      xclk[0] = 1; step(4); xclk[0] = 0; step(4);
    end
    chk(count_o == 2, "R5 counts after clear", count_o, 2);

    // R9: pending trigger survives disable
    cur_req = "R9";
    dis = 1; en = 1; step(); dis = 0; en = 0;
    chk(run_o == 0, "R9 disable wins", run_o, 0);
    swt = 1; step(); swt = 0;
    for (int i = 0; i < 2; i++) begin
      xclk[0] = 1; step(4); xclk[0] = 0; step(4);
    end
    chk(count_o == 2, "R9 hold while disabled", count_o, 2);
    en = 1; step(); en = 0;
    xclk[0] = 1; step(4); xclk[0] = 0; step(4);
    chk(count_o == 0, "R9 pending trigger kept R5", count_o, 0);

    // R3: full 16-bit wrap on master/2
    cur_req = "R3";
    sel = 3'd0;
    step(131072 + 40);
    chk(ovf_o == 1, "R3 overflow set", ovf_o, 1);
    step(50);
    chk(ovf_o == 1, "R3 overflow sticky", ovf_o, 1);

    // R4: read clears, read during wrap keeps flag
    cur_req = "R4";
    rd = 1; step(); rd = 0; step();
    chk(ovf_o == 0, "R4 read clears", ovf_o, 0);
    saw = 0;
    rd = 1;
    for (int i = 0; i < 80; i++) begin
      step();
      if (n_ovf) saw = 1;
    end
    rd = 0;
    chk(saw == 1, "R4 wrap beats read", saw, 1);
    step(10);

    done = 1;
    finish_run();
  end
endmodule